// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block sits beside a store queue and answers forwarding queries from a load pipeline. Each queue slot records one in-flight store: its doubleword-aligned virtual and physical line addresses, the byte lanes it writes, its replicated data, and two flags that say whether the address and the data are known. A load presents its own virtual and physical line addresses, the byte lanes it reads, and a vector marking the slots that hold stores older than the load. The requester computes that vector ahead of time, so no pointer arithmetic happens here.

The answer comes in two steps. In the query cycle the block returns a byte hit mask built from virtual-address matches, together with an early "data not ready" warning. One cycle later it returns the hit mask built from physical-address matches, the forwarded bytes, a data-not-ready flag with the slot index to wait on, and a flag raised when the virtual and physical match sets disagree, which calls for a pipeline flush. Every byte is taken from the youngest older store that writes it.

Slots are filled through an address write port and a data write port, and are freed by a per-slot release vector.

Top module: `stlf_unit`

## Requirements
- R1: A store's byte lanes come from its size code and the low three bits of its virtual address. The codes are 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = 8 bytes. The base pattern is shifted left by the offset, and lanes past bit 7 are dropped.
- R2: Written data is spread across the doubleword by the slot's size. For 00, byte [7:0] is copied into all 8 lanes. For 01, [15:0] is copied 4 times. For 10, [31:0] is copied twice. For 11, all 64 bits are used unchanged. Lane b of the result is bits [8b+7:8b].
- R3: A slot matches byte b of a query only when four things hold: its older bit is set, its address is valid, its line address equals the query's line address, and both its lane b and query mask bit b are set.
- R4: The older vector is one circular run of slots. Its youngest slot is the set slot i whose successor (i+1) mod N is clear; when every bit is set, the youngest is slot N-1. Each byte is served by the matching slot nearest to the youngest, counting backwards around the circle.
- R5: In the query cycle, s1_hit_mask bit b is 1 exactly when some slot matches byte b by virtual line address.
- R6: One cycle after a query, s2_hit_mask shows the bytes matched by physical line address. s2_data lane b holds the serving slot's lane b when that slot's data is valid, and 0 otherwise.
- R7: In the query cycle, s1_data_inv is 1 when any virtually matched byte is served by a slot whose data is not valid.
- R8: One cycle after a query, s2_data_inv is 1 when any physically matched byte is served by a slot without valid data. s2_data_inv_idx is the serving slot of the lowest such byte, and 0 when there is none.
- R9: One cycle after a query, s2_match_inv is 1 when the set of slots matched by virtual address differs from the set matched by physical address, comparing slot by slot with any lane overlap.
- R10: With q_valid low, s1_hit_mask and s1_data_inv are 0 in that cycle, and every stage-2 output is 0 in the next cycle. After reset, all outputs are 0.
- R11: All slot updates take effect at the next clock edge; a query sees the state from before the edge. Within one edge the order is release, then address write, then data write. An address write marks the address valid and the data not valid. A data write marks the data valid and uses the size the slot holds after the address write. A release clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Address write strobe |
| alloc_idx | input | IDX_W | Slot written by the address write |
| alloc_vaddr | input | VA_W | Full virtual address of the store |
| alloc_pline | input | PA_W-3 | Physical doubleword line address of the store |
| alloc_size | input | 2 | Size code of the store |
| data_en | input | 1 | Data write strobe |
| data_idx | input | IDX_W | Slot written by the data write |
| data_raw | input | 64 | Unreplicated store data |
| dealloc | input | N | Per-slot release |
| q_valid | input | 1 | Query valid |
| q_vline | input | VA_W-3 | Query virtual line address |
| q_pline | input | PA_W-3 | Query physical line address |
| q_mask | input | 8 | Query byte lanes |
| q_older | input | N | Slots older than the load |
| s1_hit_mask | output | 8 | Early byte hits from virtual match |
| s1_data_inv | output | 1 | Early data-not-ready warning |
| s2_hit_mask | output | 8 | Byte hits from physical match |
| s2_data | output | 64 | Forwarded bytes |
| s2_data_inv | output | 1 | Data-not-ready flag |
| s2_data_inv_idx | output | IDX_W | Slot to wait on |
| s2_match_inv | output | 1 | Virtual/physical match disagreement |

## Verification
A data write (or an address write or release) landing on a slot in the same cycle that a query selects that slot is the collision that matters. The bench drives both at once: it completes a pending store's data in the very cycle a load looks it up, and it releases and re-fills one slot in a single cycle. The query in the collision cycle must report the old state, with the data-not-ready flags up and the pending slot index returned. A second query one cycle later must see the new data forwarded with the flags clear.

// File: rtl/stlf_pkg.sv
package stlf_pkg;

    localparam int unsigned LANES   = 8;
    localparam int unsigned DW_BITS = 64;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_DBL  = 2'b11
    } st_size_e;

    // Lane pattern of a store: base width pattern shifted by the byte offset.
    function automatic logic [LANES-1:0] lane_pattern(input logic [2:0] off,
                                                      input logic [1:0] sz);
        logic [2*LANES-1:0] base;
        logic [2*LANES-1:0] shifted;
        case (st_size_e'(sz))
            SZ_BYTE: base = 16'h0001;
            SZ_HALF: base = 16'h0003;
            SZ_WORD: base = 16'h000f;
            default: base = 16'h00ff;
        endcase
        shifted = base << off;
        return shifted[LANES-1:0];
    endfunction

    // Spread the low part of the data over the doubleword by size.
    function automatic logic [DW_BITS-1:0] spread_data(input logic [DW_BITS-1:0] d,
                                                       input logic [1:0] sz);
        case (st_size_e'(sz))
            SZ_BYTE: return {8{d[7:0]}};
            SZ_HALF: return {4{d[15:0]}};
            SZ_WORD: return {2{d[31:0]}};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/stlf_entry_array.sv
module stlf_entry_array
    import stlf_pkg::*;
#(
    parameter int N    = 16,
    parameter int VA_W = 39,
    parameter int PA_W = 36,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int VT_W  = VA_W - 3,
    localparam int PT_W  = PA_W - 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_en,
    input  logic [IDX_W-1:0]              alloc_idx,
    input  logic [VA_W-1:0]               alloc_vaddr,
    input  logic [PT_W-1:0]               alloc_pline,
    input  logic [1:0]                    alloc_size,
    input  logic                          data_en,
    input  logic [IDX_W-1:0]              data_idx,
    input  logic [DW_BITS-1:0]            data_raw,
    input  logic [N-1:0]                  dealloc,
    output logic [N-1:0]                  ent_av,
    output logic [N-1:0]                  ent_dv,
    output logic [N-1:0][VT_W-1:0]        ent_vtag,
    output logic [N-1:0][PT_W-1:0]        ent_ptag,
    output logic [N-1:0][LANES-1:0]       ent_lanes,
    output logic [N-1:0][DW_BITS-1:0]     ent_data
);

    typedef struct packed {
        logic                av;
        logic                dv;
        logic [1:0]          size;
        logic [LANES-1:0]    lanes;
        logic [VT_W-1:0]     vtag;
        logic [PT_W-1:0]     ptag;
        logic [DW_BITS-1:0]  data;
    } slot_t;

    slot_t [N-1:0] slot_d, slot_q;

    always_comb begin
        logic [1:0] cur_size;
        slot_d = slot_q;
        for (int i = 0; i < N; i++) begin
            if (dealloc[i]) begin
                slot_d[i].av = 1'b0;
                slot_d[i].dv = 1'b0;
            end
        end
        if (alloc_en) begin
            slot_d[alloc_idx].av    = 1'b1;
            slot_d[alloc_idx].dv    = 1'b0;
            slot_d[alloc_idx].size  = alloc_size;
            slot_d[alloc_idx].lanes = lane_pattern(alloc_vaddr[2:0], alloc_size);
            slot_d[alloc_idx].vtag  = alloc_vaddr[VA_W-1:3];
            slot_d[alloc_idx].ptag  = alloc_pline;
        end
        cur_size = slot_d[data_idx].size;
        if (data_en) begin
            slot_d[data_idx].data = spread_data(data_raw, cur_size);
            slot_d[data_idx].dv   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign ent_av[g]    = slot_q[g].av;
        assign ent_dv[g]    = slot_q[g].dv;
        assign ent_vtag[g]  = slot_q[g].vtag;
        assign ent_ptag[g]  = slot_q[g].ptag;
        assign ent_lanes[g] = slot_q[g].lanes;
        assign ent_data[g]  = slot_q[g].data;
    end

endmodule

// File: rtl/stlf_match.sv
module stlf_match
    import stlf_pkg::*;
#(
    parameter int N     = 16,
    parameter int TAG_W = 36,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]              ent_av,
    input  logic [N-1:0][TAG_W-1:0]   ent_tag,
    input  logic [N-1:0][LANES-1:0]   ent_lanes,
    input  logic [TAG_W-1:0]          q_tag,
    input  logic [LANES-1:0]          q_mask,
    input  logic [N-1:0]              q_older,
    input  logic [IDX_W-1:0]          young_end,
    output logic [N-1:0]              line_set,
    output logic [LANES-1:0]          byte_hit,
    output logic [LANES-1:0][IDX_W-1:0] byte_sel
);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            line_set[i] = q_older[i] & ent_av[i] & (ent_tag[i] == q_tag)
                        & (|(ent_lanes[i] & q_mask));
        end
    end

    // Walk backwards from the youngest older slot; first matching slot serves the byte.
    always_comb begin
        int e;
        byte_hit = '0;
        byte_sel = '0;
        for (int b = 0; b < LANES; b++) begin
            for (int k = 0; k < N; k++) begin
                e = (int'(young_end) + N - k) % N;
                if (!byte_hit[b] && line_set[e] && ent_lanes[e][b] && q_mask[b]) begin
                    byte_hit[b] = 1'b1;
                    byte_sel[b] = IDX_W'(e);
                end
            end
        end
    end

endmodule

// File: rtl/stlf_unit.sv
module stlf_unit
    import stlf_pkg::*;
#(
    parameter int N    = 16,
    parameter int VA_W = 39,
    parameter int PA_W = 36,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic [IDX_W-1:0]     alloc_idx,
    input  logic [VA_W-1:0]      alloc_vaddr,
    input  logic [PA_W-4:0]      alloc_pline,
    input  logic [1:0]           alloc_size,
    input  logic                 data_en,
    input  logic [IDX_W-1:0]     data_idx,
    input  logic [63:0]          data_raw,
    input  logic [N-1:0]         dealloc,
    input  logic                 q_valid,
    input  logic [VA_W-4:0]      q_vline,
    input  logic [PA_W-4:0]      q_pline,
    input  logic [7:0]           q_mask,
    input  logic [N-1:0]         q_older,
    output logic [7:0]           s1_hit_mask,
    output logic                 s1_data_inv,
    output logic [7:0]           s2_hit_mask,
    output logic [63:0]          s2_data,
    output logic                 s2_data_inv,
    output logic [IDX_W-1:0]     s2_data_inv_idx,
    output logic                 s2_match_inv
);

    localparam int VT_W = VA_W - 3;
    localparam int PT_W = PA_W - 3;

    typedef struct packed {
        logic [LANES-1:0]    hit;
        logic [DW_BITS-1:0]  data;
        logic                inv;
        logic [IDX_W-1:0]    inv_idx;
        logic                minv;
    } stage2_t;

    logic [N-1:0]               ent_av, ent_dv;
    logic [N-1:0][VT_W-1:0]     ent_vtag;
    logic [N-1:0][PT_W-1:0]     ent_ptag;
    logic [N-1:0][LANES-1:0]    ent_lanes;
    logic [N-1:0][DW_BITS-1:0]  ent_data;

    logic [IDX_W-1:0]           young_end;
    logic [N-1:0]               v_set, p_set;
    logic [LANES-1:0]           v_hit, p_hit;
    logic [LANES-1:0][IDX_W-1:0] v_sel, p_sel;

    stage2_t s2_d, s2_q;

    stlf_entry_array #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (alloc_en),
        .alloc_idx   (alloc_idx),
        .alloc_vaddr (alloc_vaddr),
        .alloc_pline (alloc_pline),
        .alloc_size  (alloc_size),
        .data_en     (data_en),
        .data_idx    (data_idx),
        .data_raw    (data_raw),
        .dealloc     (dealloc),
        .ent_av      (ent_av),
        .ent_dv      (ent_dv),
        .ent_vtag    (ent_vtag),
        .ent_ptag    (ent_ptag),
        .ent_lanes   (ent_lanes),
        .ent_data    (ent_data)
    );

    // Youngest older slot: end of the circular run in q_older.
    always_comb begin
        young_end = IDX_W'(N - 1);
        for (int i = 0; i < N; i++) begin
            if (q_older[i] && !q_older[(i + 1) % N]) begin
                young_end = IDX_W'(i);
            end
        end
    end

    stlf_match #(.N(N), .TAG_W(VT_W)) u_vmatch (
        .ent_av    (ent_av),
        .ent_tag   (ent_vtag),
        .ent_lanes (ent_lanes),
        .q_tag     (q_vline),
        .q_mask    (q_mask),
        .q_older   (q_older),
        .young_end (young_end),
        .line_set  (v_set),
        .byte_hit  (v_hit),
        .byte_sel  (v_sel)
    );

    stlf_match #(.N(N), .TAG_W(PT_W)) u_pmatch (
        .ent_av    (ent_av),
        .ent_tag   (ent_ptag),
        .ent_lanes (ent_lanes),
        .q_tag     (q_pline),
        .q_mask    (q_mask),
        .q_older   (q_older),
        .young_end (young_end),
        .line_set  (p_set),
        .byte_hit  (p_hit),
        .byte_sel  (p_sel)
    );

    // Stage 1 (combinational) and next value of stage 2.
    always_comb begin
        logic v_pend;
        v_pend = 1'b0;
        for (int b = 0; b < LANES; b++) begin
            if (v_hit[b] && !ent_dv[v_sel[b]]) v_pend = 1'b1;
        end
        s1_hit_mask = q_valid ? v_hit : '0;
        s1_data_inv = q_valid & v_pend;

        s2_d = '0;
        if (q_valid) begin
            s2_d.hit  = p_hit;
            s2_d.minv = (v_set != p_set);
            for (int b = 0; b < LANES; b++) begin
                if (p_hit[b]) begin
                    if (ent_dv[p_sel[b]]) begin
                        s2_d.data[b*8 +: 8] = ent_data[p_sel[b]][b*8 +: 8];
                    end else if (!s2_d.inv) begin
                        s2_d.inv     = 1'b1;
                        s2_d.inv_idx = p_sel[b];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_q <= '0;
        end else begin
            s2_q <= s2_d;
        end
    end

    assign s2_hit_mask     = s2_q.hit;
    assign s2_data         = s2_q.data;
    assign s2_data_inv     = s2_q.inv;
    assign s2_data_inv_idx = s2_q.inv_idx;
    assign s2_match_inv    = s2_q.minv;

endmodule

// File: rtl/stlf_unit_chk.sv
module stlf_unit_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         alloc_en,
    input logic [N-1:0] dealloc,
    input logic         q_valid,
    input logic [N-1:0] q_older,
    input logic [7:0]   s1_hit_mask,
    input logic         s1_data_inv,
    input logic [7:0]   s2_hit_mask,
    input logic [63:0]  s2_data,
    input logic         s2_data_inv,
    input logic         s2_match_inv
);

    logic [63:0] hit_lanes;
    always_comb begin
        for (int b = 0; b < 8; b++) hit_lanes[b*8 +: 8] = {8{s2_hit_mask[b]}};
    end

    p_s1_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (s1_hit_mask == 8'h00 && !s1_data_inv));

    p_s2_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> (s2_hit_mask == 8'h00 && s2_data == 64'h0 && !s2_data_inv && !s2_match_inv));

    p_s1_inv_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s1_data_inv |-> (s1_hit_mask != 8'h00));

    p_s2_inv_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s2_data_inv |-> (s2_hit_mask != 8'h00));

    p_s2_unhit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_data & ~hit_lanes) == 64'h0);

    p_no_older_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_older == '0) |=> (s2_hit_mask == 8'h00 && !s2_data_inv && !s2_match_inv));

    p_release_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && $past(&dealloc && !alloc_en)) |-> (s1_hit_mask == 8'h00));

endmodule

bind stlf_unit stlf_unit_chk #(.N(N)) u_chk (.*);

// File: tb/stlf_unit_bench.sv
module stlf_unit_bench;

    localparam int N    = 16;
    localparam int VA_W = 39;
    localparam int PA_W = 36;
    localparam int IW   = 4;
    localparam int VT_W = VA_W - 3;
    localparam int PT_W = PA_W - 3;

    logic              clk, rst_n;
    logic              alloc_en, data_en, q_valid;
    logic [IW-1:0]     alloc_idx, data_idx;
    logic [VA_W-1:0]   alloc_vaddr;
    logic [PT_W-1:0]   alloc_pline, q_pline;
    logic [VT_W-1:0]   q_vline;
    logic [1:0]        alloc_size;
    logic [63:0]       data_raw;
    logic [N-1:0]      dealloc, q_older;
    logic [7:0]        q_mask;
    logic [7:0]        s1_hit_mask, s2_hit_mask;
    logic              s1_data_inv, s2_data_inv, s2_match_inv;
    logic [63:0]       s2_data;
    logic [IW-1:0]     s2_data_inv_idx;

    stlf_unit #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_stlf_unit (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_vaddr(alloc_vaddr),
        .alloc_pline(alloc_pline), .alloc_size(alloc_size),
        .data_en(data_en), .data_idx(data_idx), .data_raw(data_raw),
        .dealloc(dealloc),
        .q_valid(q_valid), .q_vline(q_vline), .q_pline(q_pline),
        .q_mask(q_mask), .q_older(q_older),
        .s1_hit_mask(s1_hit_mask), .s1_data_inv(s1_data_inv),
        .s2_hit_mask(s2_hit_mask), .s2_data(s2_data), .s2_data_inv(s2_data_inv),
        .s2_data_inv_idx(s2_data_inv_idx), .s2_match_inv(s2_match_inv)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference slot state
    bit              m_av [N];
    bit              m_dv [N];
    logic [1:0]      m_sz [N];
    logic [7:0]      m_ln [N];
    logic [VT_W-1:0] m_vt [N];
    logic [PT_W-1:0] m_pt [N];
    logic [63:0]     m_dt [N];

    typedef struct {
        logic [7:0]    hit;
        logic [63:0]   data;
        logic          inv;
        logic [IW-1:0] idx;
        logic          minv;
        string         tag;
    } exp_t;
    exp_t sb[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    function automatic logic [7:0] ref_lanes(input logic [2:0] off, input logic [1:0] sz);
        logic [15:0] w;
        w = (sz == 2'b00) ? 16'h1 : (sz == 2'b01) ? 16'h3 : (sz == 2'b10) ? 16'hf : 16'hff;
        w = w << off;
        return w[7:0];
    endfunction

    function automatic logic [63:0] ref_spread(input logic [63:0] d, input logic [1:0] sz);
        if (sz == 2'b00) return {8{d[7:0]}};
        if (sz == 2'b01) return {4{d[15:0]}};
        if (sz == 2'b10) return {2{d[31:0]}};
        return d;
    endfunction

    function automatic void ref_select(input bit phys, input logic [VT_W-1:0] vt,
                                       input logic [PT_W-1:0] pt, input logic [7:0] qm,
                                       input logic [N-1:0] older, output logic [N-1:0] set,
                                       output logic [7:0] hit, output int sel[8]);
        int yend;
        int e;
        bit tag_eq;
        yend = N - 1;
        for (int i = 0; i < N; i++) if (older[i] && !older[(i + 1) % N]) yend = i;
        for (int i = 0; i < N; i++) begin
            tag_eq = phys ? (m_pt[i] == pt) : (m_vt[i] == vt);
            set[i] = older[i] && m_av[i] && tag_eq && ((m_ln[i] & qm) != 8'h00);
        end
        for (int b = 0; b < 8; b++) begin
            hit[b] = 1'b0;
            sel[b] = 0;
            for (int k = 0; k < N; k++) begin
                e = (yend + N - k) % N;
                if (!hit[b] && set[e] && m_ln[e][b] && qm[b]) begin
                    hit[b] = 1'b1;
                    sel[b] = e;
                end
            end
        end
    endfunction

    // Driver: one cycle of writes and query; checks stage 1, pushes stage 2.
    task automatic drive_cycle(input bit a_en, input int a_idx, input logic [VA_W-1:0] a_va,
                               input logic [PT_W-1:0] a_pl, input logic [1:0] a_sz,
                               input bit d_en, input int d_idx, input logic [63:0] d_raw,
                               input logic [N-1:0] dl, input bit qv,
                               input logic [VT_W-1:0] qvl, input logic [PT_W-1:0] qpl,
                               input logic [7:0] qm, input logic [N-1:0] qo, input string tag);
        logic [N-1:0] vset, pset;
        logic [7:0]   vhit, phit, e1_hit;
        int           vsel[8];
        int           psel[8];
        bit           e1_inv;
        exp_t         x;
        @(negedge clk);
        alloc_en = a_en; alloc_idx = IW'(a_idx); alloc_vaddr = a_va;
        alloc_pline = a_pl; alloc_size = a_sz;
        data_en = d_en; data_idx = IW'(d_idx); data_raw = d_raw;
        dealloc = dl;
        q_valid = qv; q_vline = qvl; q_pline = qpl; q_mask = qm; q_older = qo;
        #1;
        ref_select(1'b0, qvl, qpl, qm, qo, vset, vhit, vsel);
        ref_select(1'b1, qvl, qpl, qm, qo, pset, phit, psel);
        e1_hit = qv ? vhit : 8'h00;
        e1_inv = 1'b0;
        for (int b = 0; b < 8; b++) if (qv && vhit[b] && !m_dv[vsel[b]]) e1_inv = 1'b1;
        n_cmp++;
        if (s1_hit_mask !== e1_hit || s1_data_inv !== e1_inv) begin
            n_bad++;
            $display("FAIL %s stage1: hit=%h/%h inv=%b/%b", tag,
                     s1_hit_mask, e1_hit, s1_data_inv, e1_inv);
        end
        x.hit = 8'h00; x.data = 64'h0; x.inv = 1'b0; x.idx = '0; x.minv = 1'b0; x.tag = tag;
        if (qv) begin
            x.hit  = phit;
            x.minv = (vset != pset);
            for (int b = 0; b < 8; b++) begin
                if (phit[b]) begin
                    if (m_dv[psel[b]]) x.data[b*8 +: 8] = m_dt[psel[b]][b*8 +: 8];
                    else if (!x.inv) begin x.inv = 1'b1; x.idx = IW'(psel[b]); end
                end
            end
        end
        sb.push_back(x);
        @(posedge clk);
        for (int i = 0; i < N; i++) if (dl[i]) begin m_av[i] = 0; m_dv[i] = 0; end
        if (a_en) begin
            m_av[a_idx] = 1; m_dv[a_idx] = 0; m_sz[a_idx] = a_sz;
            m_ln[a_idx] = ref_lanes(a_va[2:0], a_sz);
            m_vt[a_idx] = a_va[VA_W-1:3]; m_pt[a_idx] = a_pl;
        end
        if (d_en) begin
            m_dt[d_idx] = ref_spread(d_raw, m_sz[d_idx]);
            m_dv[d_idx] = 1;
        end
    endtask

    task automatic do_alloc(input int idx, input logic [VA_W-1:0] va, input logic [PT_W-1:0] pl,
                            input logic [1:0] sz);
        drive_cycle(1, idx, va, pl, sz, 0, 0, 64'h0, '0, 0, '0, '0, 8'hff, '1, "R10");
    endtask

    task automatic do_data(input int idx, input logic [63:0] d);
        drive_cycle(0, 0, '0, '0, 2'b00, 1, idx, d, '0, 0, '0, '0, 8'h00, '0, "R10");
    endtask

    task automatic do_query(input logic [VT_W-1:0] vl, input logic [PT_W-1:0] pl,
                            input logic [7:0] m, input logic [N-1:0] o, input string tag);
        drive_cycle(0, 0, '0, '0, 2'b00, 0, 0, 64'h0, '0, 1, vl, pl, m, o, tag);
    endtask

    // Monitor: compare stage-2 results one cycle after each query
    initial begin
        exp_t x;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                x = sb.pop_front();
                n_cmp++;
                if (s2_hit_mask !== x.hit || s2_data !== x.data || s2_data_inv !== x.inv ||
                    s2_data_inv_idx !== x.idx || s2_match_inv !== x.minv) begin
                    n_bad++;
                    $display("FAIL %s stage2: hit=%h/%h data=%h/%h inv=%b/%b idx=%0d/%0d minv=%b/%b",
                             x.tag, s2_hit_mask, x.hit, s2_data, x.data, s2_data_inv, x.inv,
                             s2_data_inv_idx, x.idx, s2_match_inv, x.minv);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(10 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        finish_run();
    end

    localparam logic [VT_W-1:0] VL_A = VT_W'(36'h200);
    localparam logic [PT_W-1:0] PL_A = PT_W'(33'h1000);
    localparam logic [VT_W-1:0] VL_B = VT_W'(36'h400);
    localparam logic [PT_W-1:0] PL_B = PT_W'(33'h1400);

    initial begin
        for (int i = 0; i < N; i++) begin
            m_av[i] = 0; m_dv[i] = 0; m_sz[i] = '0; m_ln[i] = '0;
            m_vt[i] = '0; m_pt[i] = '0; m_dt[i] = '0;
        end
        rst_n = 0;
        alloc_en = 0; alloc_idx = '0; alloc_vaddr = '0; alloc_pline = '0; alloc_size = '0;
        data_en = 0; data_idx = '0; data_raw = '0; dealloc = '0;
        q_valid = 0; q_vline = '0; q_pline = '0; q_mask = '0; q_older = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        n_cmp++;
        if (s1_hit_mask !== 8'h00 || s1_data_inv !== 1'b0 || s2_hit_mask !== 8'h00 ||
            s2_data !== 64'h0 || s2_data_inv !== 1'b0 || s2_match_inv !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: s1=%h s2=%h data=%h flags=%b%b%b expected all zero",
                     s1_hit_mask, s2_hit_mask, s2_data, s1_data_inv, s2_data_inv, s2_match_inv);
        end

        // Full doubleword store, forwarded in full (R5, R6)
        do_alloc(0, 39'h1000, PL_A, 2'b11);
        do_data(0, 64'h1122334455667788);
        do_query(VL_A, PL_A, 8'hff, 16'h0001, "R6");
        do_query(VL_A, PL_A, 8'h0f, 16'h0001, "R5");

        // Byte store overlays one lane (R1, R2, R4); excluded when not older (R3)
        do_alloc(1, 39'h1005, PL_A, 2'b00);
        do_data(1, 64'h00000000000000ab);
        do_query(VL_A, PL_A, 8'hff, 16'h0003, "R4");
        do_query(VL_A, PL_A, 8'hff, 16'h0001, "R3");
        do_query(VL_A, PL_A, 8'h00, 16'h0003, "R3");

        // Halfword store at offset 2 (R1, R2)
        do_alloc(2, 39'h1002, PL_A, 2'b01);
        do_data(2, 64'h000000000000beef);
        do_query(VL_A, PL_A, 8'hff, 16'h0007, "R1");
        do_query(VL_A, PL_A, 8'h0c, 16'h0007, "R2");

        // Word store without data: not-ready flags and slot index (R7, R8)
        do_alloc(3, 39'h1004, PL_A, 2'b10);
        do_query(VL_A, PL_A, 8'hff, 16'h000f, "R7");
        do_query(VL_A, PL_A, 8'hf0, 16'h000f, "R8");

        // Data write colliding with a query on the same slot (R11)
        drive_cycle(0, 0, '0, '0, 2'b00, 1, 3, 64'h00000000cafef00d, '0,
                    1, VL_A, PL_A, 8'hff, 16'h000f, "R11");
        do_query(VL_A, PL_A, 8'hff, 16'h000f, "R11");

        // Virtual/physical disagreement (R9)
        do_alloc(4, 39'h2000, PL_B, 2'b11);
        do_data(4, 64'h0102030405060708);
        do_query(VL_B, PT_W'(33'h1500), 8'hff, 16'h001f, "R9");
        do_query(VT_W'(36'h401), PL_B, 8'hff, 16'h001f, "R9");
        do_query(VL_B, PL_B, 8'hff, 16'h001f, "R9");

        // Wrapped older run (R4)
        do_alloc(14, 39'h1000, PL_A, 2'b11);
        do_data(14, 64'he0e1e2e3e4e5e6e7);
        do_alloc(15, 39'h1003, PL_A, 2'b00);
        do_data(15, 64'h000000000000005a);
        do_query(VL_A, PL_A, 8'hff, 16'hc001, "R4");
        do_query(VL_A, PL_A, 8'hff, 16'hc000, "R4");
        do_query(VL_A, PL_A, 8'hff, 16'hffff, "R4");

        // Invalid query with everything else set (R10)
        drive_cycle(0, 0, '0, '0, 2'b00, 0, 0, 64'h0, '0, 0, VL_A, PL_A, 8'hff, 16'hffff, "R10");

        // Release a slot (R11)
        drive_cycle(0, 0, '0, '0, 2'b00, 0, 0, 64'h0, 16'h0002, 0, '0, '0, 8'h00, '0, "R11");
        do_query(VL_A, PL_A, 8'hff, 16'h0003, "R11");

        // Release and re-fill the same slot in one cycle: fill wins (R11)
        drive_cycle(1, 1, 39'h1001, PL_A, 2'b00, 0, 0, 64'h0, 16'h0002,
                    1, VL_A, PL_A, 8'hff, 16'h0003, "R11");
        do_query(VL_A, PL_A, 8'hff, 16'h0003, "R11");
        do_data(1, 64'h0000000000000077);
        do_query(VL_A, PL_A, 8'hff, 16'h0003, "R2");

        // Release everything (R11)
        drive_cycle(0, 0, '0, '0, 2'b00, 0, 0, 64'h0, 16'hffff, 0, '0, '0, 8'h00, '0, "R11");
        do_query(VL_A, PL_A, 8'hff, 16'hffff, "R11");

        drive_cycle(0, 0, '0, '0, 2'b00, 0, 0, 64'h0, '0, 0, '0, '0, 8'h00, '0, "R10");
        repeat (2) @(posedge clk);
        #2;
        finish_run();
    end

endmodule